// File: doc/BRIEF.md
# Multi-Event Trigger Capture Buffer

This block manages the acquisition memory of one sample stream. The memory is split into a power-of-two number of equal event slots. The slot that is recording receives every valid sample at a write offset that wraps around, so the slot always holds the most recent samples before a trigger. When a trigger is accepted, a programmable number of further samples is written. The slot is then frozen as a complete event, and the next valid sample goes straight into the following slot.

Frozen events leave the block in the order they were captured, through a read port that is independent of the write side. The reader gives a sample index, where index 0 is the oldest sample of the event, and gets the data one clock later. A one-cycle release strobe returns the oldest slot to the free pool. Each event carries the value of a free-running trigger timestamp counter, which a sync pulse clears. Occupancy, busy and full flags report how many slots are still free.

Top module: `mev_buffer`

## Requirements
- R1: A sample is stored only in a cycle where `smp_valid_i` is high. Within the recording slot the write offset advances by one and wraps at the slot size, so a frozen event holds the slot-size most recent samples ending at the last post-trigger sample.
- R2: A trigger counts only in a cycle where `smp_valid_i` is high (the trigger sample is stored). With post count N, the slot freezes on the edge that stores the N-th following valid sample, and `occ_o` rises on that edge. With N = 0 it freezes on the trigger sample itself. N must be smaller than the slot size.
- R3: The valid sample after a freeze is stored at offset 0 of the next slot, in cyclic order, so no sample is lost between events.
- R4: `cfg_slot_log_i` = k selects 2^k slots of 2^(ADDR_W-k) samples each, with k from 0 to SLOT_LOG_MAX. The slot index occupies the upper k address bits.
- R5: While `evt_ready_o` is high, `rd_data_o` returns sample `rd_idx_i` of the oldest frozen event one clock after the index is applied. Index 0 is the oldest sample, and the index wraps within the slot.
- R6: The timestamp counter increments on every clock edge and returns to 0 on the edge where `sync_i` is high. `evt_ts_o` shows the counter value from the trigger cycle of the oldest event.
- R7: A trigger during the post-trigger count of the current event is ignored.
- R8: When all 2^k slots hold unread events, `full_o` is high, and triggers and samples are discarded.
- R9: `busy_o` is high exactly when `occ_o` equals 2^k - 1.
- R10: `occ_o` counts the frozen, unread slots. A `rd_done_i` pulse with `occ_o` > 0 releases the oldest slot, and a pulse with `occ_o` = 0 has no effect.
- R11: Events can be read out while the write side keeps storing samples into another slot.
- R12: After reset `occ_o` is 0, `full_o` and `evt_ready_o` are low, the timestamp is 0 and recording starts at slot 0, offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_slot_log_i | input | $clog2(SLOT_LOG_MAX+1) | Log2 of the slot count |
| cfg_post_i | input | ADDR_W | Post-trigger sample count |
| smp_valid_i | input | 1 | Sample valid |
| smp_data_i | input | DATA_W | Sample value |
| trig_i | input | 1 | Trigger request |
| sync_i | input | 1 | Timestamp clear |
| rd_idx_i | input | ADDR_W | Sample index within the oldest event |
| rd_done_i | input | 1 | Release the oldest event |
| rd_data_o | output | DATA_W | Read sample, one clock after the index |
| evt_ready_o | output | 1 | At least one event is frozen |
| evt_ts_o | output | TS_W | Trigger timestamp of the oldest event |
| occ_o | output | SLOT_LOG_MAX+1 | Frozen, unread slot count |
| busy_o | output | 1 | Only one free slot left |
| full_o | output | 1 | No free slot left |

## Verification
The properties assume that `cfg_slot_log_i` and `cfg_post_i` change only while reset is active, that k does not exceed SLOT_LOG_MAX, and that the post count is below the slot size. The stimulus keeps to these limits: each configuration is set while `rst_ni` is low, and the sweep uses every slot count of a 32-entry memory with post counts from 0 up to slot size minus one. Before every trigger the bench supplies exactly slot size minus post minus one samples, so every event is filled by samples that follow the previous freeze. This makes the expected content of each event a simple arithmetic run of sample numbers.

// File: rtl/mev_pkg.sv
package mev_pkg;
  localparam int unsigned TS_W = 32;
endpackage

// File: rtl/mev_ts_counter.sv
module mev_ts_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_i,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ts_o <= '0;
    else if (sync_i) ts_o <= '0;
    else             ts_o <= ts_o + TS_W'(1);
  end
endmodule

// File: rtl/mev_sample_ram.sv
module mev_sample_ram #(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/mev_slot_ctrl.sv
module mev_slot_ctrl #(
  parameter  int ADDR_W       = 10,
  parameter  int SLOT_LOG_MAX = 10,
  parameter  int TS_W         = 32,
  localparam int SLW          = $clog2(SLOT_LOG_MAX + 1),
  localparam int CNT_W        = SLOT_LOG_MAX + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLW-1:0]    cfg_slot_log_i,
  input  logic [ADDR_W-1:0] cfg_post_i,
  input  logic              smp_valid_i,
  input  logic              trig_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [ADDR_W-1:0] rd_idx_i,
  input  logic              rd_done_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [TS_W-1:0]   evt_ts_o,
  output logic [CNT_W-1:0]  occ_o,
  output logic              evt_ready_o,
  output logic              busy_o,
  output logic              full_o
);
  localparam int NSLOT = 1 << SLOT_LOG_MAX;

  logic [SLOT_LOG_MAX-1:0] wr_slot_q, rd_slot_q;
  logic [ADDR_W-1:0]       wr_off_q, post_left_q, off_mask, start_ptr;
  logic                    in_post_q;
  logic [TS_W-1:0]         trig_ts_q, evt_ts;
  logic [CNT_W-1:0]        occ_q, nslots, slot_mask;
  logic [7:0]              shamt;
  logic                    wr_en, trig_acc, last_post, freeze, release_ev;

  logic [ADDR_W-1:0] start_mem [NSLOT];
  logic [TS_W-1:0]   ts_mem    [NSLOT];

  function automatic logic [SLOT_LOG_MAX-1:0] bump(input logic [SLOT_LOG_MAX-1:0] s,
                                                   input logic [CNT_W-1:0] m);
    return SLOT_LOG_MAX'((CNT_W'(s) + CNT_W'(1)) & m);
  endfunction

  // geometry: slot index in the upper k bits, offset in the rest
  assign nslots    = CNT_W'(1) << cfg_slot_log_i;
  assign slot_mask = nslots - CNT_W'(1);
  assign off_mask  = {ADDR_W{1'b1}} >> cfg_slot_log_i;
  assign shamt     = 8'(ADDR_W) - 8'(cfg_slot_log_i);

  assign full_o      = (occ_q == nslots);
  assign busy_o      = (occ_q == slot_mask);
  assign evt_ready_o = (occ_q != '0);
  assign occ_o       = occ_q;

  assign wr_en      = smp_valid_i && !full_o;
  assign trig_acc   = wr_en && trig_i && !in_post_q;
  assign last_post  = in_post_q && (post_left_q == ADDR_W'(1));
  assign freeze     = wr_en && ((trig_acc && cfg_post_i == '0) || last_post);
  assign release_ev = rd_done_i && evt_ready_o;
  assign start_ptr  = (wr_off_q + ADDR_W'(1)) & off_mask;
  assign evt_ts     = trig_acc ? ts_i : trig_ts_q;

  assign we_o     = wr_en;
  assign waddr_o  = (ADDR_W'(wr_slot_q) << shamt) | wr_off_q;
  assign raddr_o  = (ADDR_W'(rd_slot_q) << shamt) |
                    ((start_mem[rd_slot_q] + rd_idx_i) & off_mask);
  assign evt_ts_o = ts_mem[rd_slot_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_slot_q   <= '0;
      rd_slot_q   <= '0;
      wr_off_q    <= '0;
      post_left_q <= '0;
      in_post_q   <= 1'b0;
      trig_ts_q   <= '0;
      occ_q       <= '0;
    end else begin
      if (wr_en) begin
        if (freeze) begin
          wr_slot_q <= bump(wr_slot_q, slot_mask);
          wr_off_q  <= '0;
          in_post_q <= 1'b0;
        end else begin
          wr_off_q <= start_ptr;
          if (trig_acc) begin
            in_post_q   <= 1'b1;
            post_left_q <= cfg_post_i;
            trig_ts_q   <= ts_i;
          end else if (in_post_q) begin
            post_left_q <= post_left_q - ADDR_W'(1);
          end
        end
      end
      if (release_ev) rd_slot_q <= bump(rd_slot_q, slot_mask);
      occ_q <= occ_q + CNT_W'(freeze) - CNT_W'(release_ev);
    end
  end

  // per-slot event descriptor, written once at freeze
  always_ff @(posedge clk_i) begin
    if (freeze) begin
      start_mem[wr_slot_q] <= start_ptr;
      ts_mem[wr_slot_q]    <= evt_ts;
    end
  end
endmodule

// File: rtl/mev_buffer.sv
module mev_buffer #(
  parameter  int DATA_W       = 10,
  parameter  int ADDR_W       = 10,
  parameter  int SLOT_LOG_MAX = 10,
  parameter  int TS_W         = mev_pkg::TS_W,
  localparam int SLW          = $clog2(SLOT_LOG_MAX + 1),
  localparam int CNT_W        = SLOT_LOG_MAX + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLW-1:0]    cfg_slot_log_i,
  input  logic [ADDR_W-1:0] cfg_post_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              trig_i,
  input  logic              sync_i,
  input  logic [ADDR_W-1:0] rd_idx_i,
  input  logic              rd_done_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              evt_ready_o,
  output logic [TS_W-1:0]   evt_ts_o,
  output logic [CNT_W-1:0]  occ_o,
  output logic              busy_o,
  output logic              full_o
);
  logic [TS_W-1:0]   ts_now;
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;

  mev_ts_counter #(.TS_W(TS_W)) i_ts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_i),
    .ts_o  (ts_now)
  );

  mev_slot_ctrl #(
    .ADDR_W      (ADDR_W),
    .SLOT_LOG_MAX(SLOT_LOG_MAX),
    .TS_W        (TS_W)
  ) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_slot_log_i(cfg_slot_log_i),
    .cfg_post_i    (cfg_post_i),
    .smp_valid_i   (smp_valid_i),
    .trig_i        (trig_i),
    .ts_i          (ts_now),
    .rd_idx_i      (rd_idx_i),
    .rd_done_i     (rd_done_i),
    .we_o          (we),
    .waddr_o       (waddr),
    .raddr_o       (raddr),
    .evt_ts_o      (evt_ts_o),
    .occ_o         (occ_o),
    .evt_ready_o   (evt_ready_o),
    .busy_o        (busy_o),
    .full_o        (full_o)
  );

  mev_sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ram (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(smp_data_i),
    .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/mev_buffer_chk.sv
module mev_buffer_chk #(
  parameter  int ADDR_W       = 10,
  parameter  int SLOT_LOG_MAX = 10,
  parameter  int TS_W         = 32,
  localparam int SLW          = $clog2(SLOT_LOG_MAX + 1),
  localparam int CNT_W        = SLOT_LOG_MAX + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic             sync_i,
  input logic [SLW-1:0]   cfg_slot_log_i,
  input logic [CNT_W-1:0] occ_o,
  input logic             full_o,
  input logic             evt_ready_o,
  input logic [TS_W-1:0]  ts_now
);
  logic [CNT_W:0] nslots_w;
  assign nslots_w = (CNT_W+1)'(1) << cfg_slot_log_i;

  // R8
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, occ_o} <= nslots_w);

  // R8
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> occ_o <= $past(occ_o));

  // R2
  no_freeze_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> occ_o <= $past(occ_o));

  // R10
  occ_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ({1'b0, occ_o} <= {1'b0, $past(occ_o)} + 1'b1) &&
             ({1'b0, occ_o} + 1'b1 >= {1'b0, $past(occ_o)}));

  // R10
  empty_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_ready_o |=> occ_o <= CNT_W'(1));

  // R6
  ts_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> ts_now == '0);

  // R6
  ts_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> ts_now == $past(ts_now) + TS_W'(1));
endmodule

bind mev_buffer mev_buffer_chk #(
  .ADDR_W      (ADDR_W),
  .SLOT_LOG_MAX(SLOT_LOG_MAX),
  .TS_W        (TS_W)
) i_mev_buffer_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .smp_valid_i   (smp_valid_i),
  .sync_i        (sync_i),
  .cfg_slot_log_i(cfg_slot_log_i),
  .occ_o         (occ_o),
  .full_o        (full_o),
  .evt_ready_o   (evt_ready_o),
  .ts_now        (ts_now)
);

// File: tb/test_mev_buffer.sv
module test_mev_buffer;
  localparam int DW  = 10;
  localparam int AW  = 5;
  localparam int SLM = 3;
  localparam int SLW = $clog2(SLM + 1);
  localparam int CW  = SLM + 1;
  localparam int TSW = 32;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [SLW-1:0] cfg_slot_log_i = '0;
  logic [AW-1:0]  cfg_post_i = '0;
  logic           smp_valid_i = 1'b0;
  logic [DW-1:0]  smp_data_i = '0;
  logic           trig_i = 1'b0;
  logic           sync_i = 1'b0;
  logic [AW-1:0]  rd_idx_i = '0;
  logic           rd_done_i = 1'b0;
  logic [DW-1:0]  rd_data_o;
  logic           evt_ready_o;
  logic [TSW-1:0] evt_ts_o;
  logic [CW-1:0]  occ_o;
  logic           busy_o, full_o;

  always #5 clk_i = ~clk_i;

  mev_buffer #(.DATA_W(DW), .ADDR_W(AW), .SLOT_LOG_MAX(SLM), .TS_W(TSW)) i_mev_buffer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_slot_log_i(cfg_slot_log_i), .cfg_post_i(cfg_post_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .trig_i(trig_i), .sync_i(sync_i),
    .rd_idx_i(rd_idx_i), .rd_done_i(rd_done_i), .rd_data_o(rd_data_o),
    .evt_ready_o(evt_ready_o), .evt_ts_o(evt_ts_o), .occ_o(occ_o),
    .busy_o(busy_o), .full_o(full_o)
  );

  int checks = 0;
  int errors = 0;
  int seq = 0;
  int last_trig_seq = 0;
  logic [TSW-1:0] last_trig_ts = '0;
  logic [TSW-1:0] tb_ts;
  int exp_last [8];
  logic [TSW-1:0] exp_ts [8];
  int post_tab [4] = '{5, 0, 7, 2};

  // expected timestamp, from R6
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tb_ts <= '0;
    else if (sync_i) tb_ts <= '0;
    else             tb_ts <= tb_ts + 1;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit t);
    @(negedge clk_i);
    smp_valid_i = v;
    trig_i      = t;
    smp_data_i  = DW'(seq);
    if (t) begin
      last_trig_seq = seq;
      last_trig_ts  = tb_ts;
    end
    @(posedge clk_i);
    if (v) seq++;
  endtask

  task automatic settle();
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    trig_i      = 1'b0;
    rd_done_i   = 1'b0;
    sync_i      = 1'b0;
  endtask

  task automatic feed(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0);
      if (gap) drive(1'b0, 1'b0);
    end
  endtask

  // R5 R1 R3 R11: read the head event while samples keep arriving
  task automatic read_event(input int size, input int last);
    for (int j = 0; j <= size; j++) begin
      @(negedge clk_i);
      if (j > 0) chk("R5 R1 R3 R11 event sample", rd_data_o, (last - size + j) & 1023);
      if (j < size) rd_idx_i = AW'(j);
      smp_valid_i = 1'b1;
      trig_i      = 1'b0;
      smp_data_i  = DW'(seq);
      @(posedge clk_i);
      seq++;
    end
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    rd_done_i   = 1'b1;
    @(posedge clk_i);
    settle();
  endtask

  task automatic run_cfg(input int k);
    int size, n, p;
    bit gap;
    size = 1 << (AW - k);
    n    = 1 << k;
    p    = post_tab[k];
    gap  = k[0];
    rst_ni = 1'b0;
    cfg_slot_log_i = SLW'(k);
    cfg_post_i     = AW'(p);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    seq = 0;
    chk("R12 occ", occ_o, 0);
    chk("R12 full", full_o, 0);
    chk("R12 ready", evt_ready_o, 0);
    chk("R9 busy at reset", busy_o, n == 1);

    drive(1'b0, 1'b1);  // R2: trigger without a sample
    settle();
    chk("R2 trigger without sample", occ_o, 0);

    for (int e = 0; e < n; e++) begin
      feed(size - 1 - p, gap);
      drive(1'b1, 1'b1);
      exp_last[e] = last_trig_seq + p;
      exp_ts[e]   = last_trig_ts;
      if (gap) drive(1'b0, 1'b0);
      if (p > 0) begin
        for (int i = 0; i < p - 1; i++) begin
          drive(1'b1, e == 0 && i == 0);  // R7: trigger inside the post window
          if (gap) drive(1'b0, 1'b0);
        end
        settle();
        chk("R2 R7 not frozen before last post sample", occ_o, e);
        drive(1'b1, 1'b0);
      end
      settle();
      chk("R2 frozen after post count", occ_o, e + 1);
      chk("R9 busy", busy_o, e + 1 == n - 1);
      chk("R4 full after 2^k events", full_o, e + 1 == n);
    end

    drive(1'b1, 1'b1);  // R8: trigger while full
    feed(size, 1'b0);
    settle();
    chk("R8 occ held when full", occ_o, n);
    chk("R8 full", full_o, 1);

    for (int e = 0; e < n; e++) begin
      chk("R5 ready", evt_ready_o, 1);
      chk("R6 event timestamp", evt_ts_o, exp_ts[e]);
      read_event(size, exp_last[e]);
      chk("R10 release", occ_o, n - 1 - e);
    end

    @(negedge clk_i);
    rd_done_i = 1'b1;
    @(posedge clk_i);
    settle();
    chk("R10 release on empty", occ_o, 0);
    chk("R10 ready low", evt_ready_o, 0);

    @(negedge clk_i);
    sync_i = 1'b1;
    @(posedge clk_i);
    settle();
    feed(size - 1 - p, gap);
    drive(1'b1, 1'b1);
    exp_last[0] = last_trig_seq + p;
    exp_ts[0]   = last_trig_ts;
    if (gap) drive(1'b0, 1'b0);
    feed(p, gap);
    settle();
    chk("R3 capture after resume", occ_o, 1);
    chk("R6 timestamp after sync", evt_ts_o, exp_ts[0]);
    read_event(size, exp_last[0]);
    chk("R10 empty again", occ_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k <= SLM; k++) run_cfg(k);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule